// File: doc/BRIEF.md
# Early-Terminating Sequential Multiplier

This block multiplies two 32-bit operands over several clock cycles and can optionally add the product to a 64-bit accumulator value. The multiplier operand is consumed eight bits per compute cycle, least-significant slice first. After each slice, the block looks at the multiplier bits it has not yet used. If they can no longer change the product, it stops. Those bits must be all zeros, or all ones when the operands are signed.

When the signed tail is all ones, the block applies one correction term. It subtracts the multiplicand, shifted to the tail position. Because of this, a small negative multiplier finishes as quickly as a small positive one.

A request is made by pulsing `start` while the block is idle. The operands, the sign select, the accumulate enable and the result-width select are captured on that edge. `busy` stays high for the one to four compute cycles. `done` then pulses for one cycle, and `result` carries either the full 64-bit value or the low 32 bits zero-extended.

Top module: `etmul_top`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: With `sgn`=0, `acc_en`=0 and `long_mode`=1, `result` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R3: With `sgn`=1, `acc_en`=0 and `long_mode`=1, `result` equals the two's-complement 64-bit product of `op_a` and `op_b`, both read as signed.
- R4: `done` is first seen high exactly N rising edges after the edge that accepts `start`. N is the least k in 1..4 for which the multiplier B meets the following bound. When `sgn`=0 the bound is B < 2^(8k). When `sgn`=1 it is -2^(8k) <= B < 2^(8k), with B signed. `busy` is high during those N cycles and low when `done` is high.
- R5: With `acc_en`=1, `result` equals `acc_in` plus the product, taken modulo 2^64. The product is signed or unsigned as selected by `sgn`. With `acc_en`=0, `acc_in` has no effect.
- R6: With `long_mode`=0, `result[31:0]` is the low 32 bits of the product or sum, and `result[63:32]` is 0. The upper bits are dropped with no indication.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: A `start` pulse while `busy` is high is ignored. The running operation keeps its latency and its result.
- R9: `result` holds its value from one `done` pulse until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier, consumed in 8-bit slices |
| sgn | input | 1 | 1 = signed operands, 0 = unsigned |
| acc_en | input | 1 | 1 = add acc_in to the product |
| acc_in | input | 64 | Accumulator addend |
| long_mode | input | 1 | 1 = 64-bit result, 0 = low 32 bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Product or sum |

## Verification
An error in the termination detector shows up at the ports as a wrong cycle count, as soon as the first operation runs. It can also corrupt the result, because the block may stop before a non-trivial slice is used, or use slices past the true end. A wrong saved multiplier slice, or a missing signed correction, changes the value on `result` when the very next `done` pulse arrives. This is most visible for negative multipliers whose width is not a multiple of eight. A control state stuck in run leaves `busy` high past four cycles. That is caught inside the window of one operation.

// File: rtl/etmul_pkg.sv
package etmul_pkg;
  localparam int ETM_W   = 32;
  localparam int ETM_S   = 8;
  localparam int ETM_NST = ETM_W / ETM_S;
  localparam int ETM_PW  = 2 * ETM_W;
  localparam int ETM_CW  = $clog2(ETM_NST + 1);

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} etm_state_e;

  // widen an operand to product width, sign- or zero-filled
  function automatic logic [ETM_PW-1:0] ext_op(input logic [ETM_W-1:0] v, input logic sgn);
    ext_op = sgn ? {{ETM_W{v[ETM_W-1]}}, v} : {{ETM_W{1'b0}}, v};
  endfunction

  // one slice partial product placed at slice position k
  function automatic logic [ETM_PW-1:0] slice_pp(input logic [ETM_PW-1:0] a,
                                                 input logic [ETM_S-1:0] s,
                                                 input logic [ETM_CW-1:0] k);
    logic [ETM_PW-1:0] m;
    m = a * {{(ETM_PW-ETM_S){1'b0}}, s};
    slice_pp = m << (ETM_S * int'(k));
  endfunction

  // correction for an all-ones tail that starts at slice position k
  function automatic logic [ETM_PW-1:0] tail_corr(input logic [ETM_PW-1:0] a,
                                                  input logic [ETM_CW-1:0] k);
    tail_corr = a << (ETM_S * int'(k));
  endfunction

  // drop the consumed slice, keeping the sign when signed
  function automatic logic [ETM_W-1:0] drop_slice(input logic [ETM_W-1:0] b, input logic sgn);
    logic [ETM_W-1:0] r;
    if (sgn) r = ETM_W'($signed(b) >>> ETM_S);
    else     r = b >> ETM_S;
    drop_slice = r;
  endfunction
endpackage

// File: rtl/etmul_ctrl.sv
module etmul_ctrl
  import etmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              term_hit,
  output logic              accept,
  output logic              stage_fire,
  output logic              finish,
  output logic              busy,
  output logic              last_stage,
  output logic [ETM_CW-1:0] stage_idx
);
  etm_state_e        state_q;
  logic [ETM_CW-1:0] k_q;

  assign accept     = (state_q == ST_IDLE) && start;
  assign stage_fire = (state_q == ST_RUN);
  assign finish     = stage_fire && term_hit;
  assign busy       = stage_fire;
  assign last_stage = (k_q == ETM_CW'(ETM_NST - 1));
  assign stage_idx  = k_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      k_q     <= '0;
    end else if (finish) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
    end else if (stage_fire) begin
      k_q <= k_q + 1'b1;
    end
  end
endmodule

// File: rtl/etmul_term.sv
module etmul_term
  import etmul_pkg::*;
#(
  parameter bit EARLY = 1'b1
) (
  input  logic [ETM_W-1:0] b_cur,
  input  logic             sgn,
  input  logic             last_stage,
  output logic [ETM_W-1:0] b_next,
  output logic             term_hit,
  output logic             neg_tail
);
  logic tail_zero;
  logic tail_ones;

  assign b_next    = drop_slice(b_cur, sgn);
  assign tail_zero = (b_next == '0);
  assign tail_ones = sgn && (b_next == '1);
  assign neg_tail  = tail_ones && (EARLY || last_stage);

  generate
    if (EARLY) begin : g_early
      assign term_hit = tail_zero || tail_ones || last_stage;
    end else begin : g_full
      assign term_hit = last_stage;
    end
  endgenerate
endmodule

// File: rtl/etmul_stage.sv
module etmul_stage
  import etmul_pkg::*;
(
  input  logic [ETM_PW-1:0] acc,
  input  logic [ETM_PW-1:0] a_ext,
  input  logic [ETM_S-1:0]  slice,
  input  logic [ETM_CW-1:0] k,
  input  logic              neg_tail,
  output logic [ETM_PW-1:0] acc_next,
  output logic [ETM_PW-1:0] fin_sum
);
  logic [ETM_CW-1:0] k_tail;

  assign k_tail   = k + 1'b1;
  assign acc_next = acc + slice_pp(a_ext, slice, k);
  assign fin_sum  = neg_tail ? (acc_next - tail_corr(a_ext, k_tail)) : acc_next;
endmodule

// File: rtl/etmul_top.sv
module etmul_top
  import etmul_pkg::*;
#(
  parameter bit EARLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ETM_W-1:0]  op_a,
  input  logic [ETM_W-1:0]  op_b,
  input  logic              sgn,
  input  logic              acc_en,
  input  logic [ETM_PW-1:0] acc_in,
  input  logic              long_mode,
  output logic              busy,
  output logic              done,
  output logic [ETM_PW-1:0] result
);
  localparam int HW = ETM_PW - ETM_W;

  logic [ETM_PW-1:0] a_ext_q, acc_q, result_q;
  logic [ETM_W-1:0]  b_q;
  logic              sgn_q, long_q, done_q;

  logic              accept, stage_fire, finish, last_stage, term_hit, neg_tail;
  logic [ETM_CW-1:0] stage_idx;
  logic [ETM_W-1:0]  b_next;
  logic [ETM_PW-1:0] acc_next, fin_sum;

  etmul_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .term_hit   (term_hit),
    .accept     (accept),
    .stage_fire (stage_fire),
    .finish     (finish),
    .busy       (busy),
    .last_stage (last_stage),
    .stage_idx  (stage_idx)
  );

  etmul_term #(.EARLY(EARLY)) u_term (
    .b_cur      (b_q),
    .sgn        (sgn_q),
    .last_stage (last_stage),
    .b_next     (b_next),
    .term_hit   (term_hit),
    .neg_tail   (neg_tail)
  );

  etmul_stage u_stage (
    .acc      (acc_q),
    .a_ext    (a_ext_q),
    .slice    (b_q[ETM_S-1:0]),
    .k        (stage_idx),
    .neg_tail (neg_tail),
    .acc_next (acc_next),
    .fin_sum  (fin_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ext_q <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      sgn_q   <= 1'b0;
      long_q  <= 1'b0;
    end else if (accept) begin
      a_ext_q <= ext_op(op_a, sgn);
      b_q     <= op_b;
      acc_q   <= acc_en ? acc_in : '0;
      sgn_q   <= sgn;
      long_q  <= long_mode;
    end else if (stage_fire) begin
      b_q   <= b_next;
      acc_q <= acc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish)
        result_q <= long_q ? fin_sum : {{HW{1'b0}}, fin_sum[ETM_W-1:0]};
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/etmul_chk.sv
module etmul_chk
  import etmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              finish,
  input logic              long_q,
  input logic [ETM_PW-1:0] result
);
  logic [ETM_CW:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (bcnt < (ETM_CW+1)'(ETM_NST))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |=> (done || $stable(result))); // R9
  AST_SHORT_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (done && !long_q) |-> (result[ETM_PW-1:ETM_W] == '0)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !finish) |=> (busy && !done)); // R8
endmodule

bind etmul_top etmul_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .finish (finish),
  .long_q (long_q),
  .result (result)
);

// File: tb/tb_etmul_top.sv
module tb_etmul_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sgn = 1'b0, acc_en = 1'b0, long_mode = 1'b1;
  logic [63:0] acc_in = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  etmul_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .sgn(sgn), .acc_en(acc_en), .acc_in(acc_in), .long_mode(long_mode),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input logic s,
                                        input logic ae, input logic [63:0] acc, input logic lm);
    logic [63:0] p;
    if (s) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    else   p = {32'd0, a} * {32'd0, b};
    if (ae) p = p + acc;
    if (!lm) p = {32'd0, p[31:0]};
    return p;
  endfunction

  function automatic int lat_model(input logic [31:0] b, input logic s);
    longint bv;
    bv = s ? longint'($signed(b)) : longint'({32'd0, b});
    for (int k = 1; k <= 4; k++) begin
      longint lim;
      lim = longint'(1) << (8 * k);
      if (s) begin
        if (bv >= -lim && bv < lim) return k;
      end else if (bv < lim) return k;
    end
    return 4;
  endfunction

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic ae, input logic [63:0] acc, input logic lm);
    @(negedge clk);
    op_a = a; op_b = b; sgn = s; acc_en = ae; acc_in = acc; long_mode = lm; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // after launch returns, one negedge past the accept edge has been seen
  task automatic wait_done(output int cnt, input bit poke);
    cnt = 1;
    if (poke) begin
      op_a = 32'h1111_1111; op_b = 32'h0000_0002; acc_en = 1'b1; acc_in = 64'hFFFF; start = 1'b1;
    end
    while (!done && cnt < 12) begin
      @(negedge clk);
      start = 1'b0;
      if (!done) cnt++;
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic ae, input logic [63:0] acc, input logic lm, input bit poke);
    int cnt;
    logic [63:0] exp;
    exp = model(a, b, s, ae, acc, lm);
    launch(a, b, s, ae, acc, lm);
    check({tag, " busy after accept R4"}, {63'd0, busy}, 64'd1);
    wait_done(cnt, poke);
    check({tag, " result"}, result, exp);
    check({tag, " latency R4"}, 64'(cnt), 64'(lat_model(b, s)));
    check({tag, " busy low at done R4"}, {63'd0, busy}, 64'd0);
    @(negedge clk);
    check({tag, " done one cycle R7"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    check("R1 busy at reset", {63'd0, busy}, 64'd0);
    check("R1 done at reset", {63'd0, done}, 64'd0);
    check("R1 result at reset", result, 64'd0);
  endtask

  task automatic t_unsigned;
    run_op("R2 u8",  32'hDEAD_BEEF, 32'h0000_005A, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R2 u16", 32'hFFFF_FFFF, 32'h0000_1234, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R2 u24", 32'h1234_5678, 32'h00AB_CDEF, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R2 u32", 32'hFFFF_FFFF, 32'hDEAD_BEEF, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R2 zero", 32'h8765_4321, 32'h0000_0000, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R2 u allones", 32'h0000_0003, 32'hFFFF_FFFF, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_signed;
    run_op("R3 s neg1",  32'h0000_1234, 32'hFFFF_FFFF, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R3 s pos200", 32'hFFFF_FF00, 32'h0000_00C8, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R3 s m300",  32'h8000_0000, 32'hFFFF_FED4, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R3 s m70000", 32'h7FFF_FFFF, 32'hFFFE_EE90, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R3 s min",   32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R3 s 24bit", 32'hFEDC_BA98, 32'h0012_3456, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_accum;
    run_op("R5 u acc", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 64'hFFFF_FFFF_0000_0005, 1'b1, 1'b0);
    run_op("R5 s acc", 32'hFFFF_FFF0, 32'h0000_0010, 1'b1, 1'b1, 64'h0000_0000_0000_0100, 1'b1, 1'b0);
    run_op("R5 acc off", 32'h0000_0007, 32'h0000_0009, 1'b0, 1'b0, 64'h5555_5555_5555_5555, 1'b1, 1'b0);
  endtask

  task automatic t_short;
    run_op("R6 short wrap", 32'hFFFF_FFFF, 32'h0001_0000, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0);
    run_op("R6 short s acc", 32'hFFFF_FFFD, 32'h0000_0007, 1'b1, 1'b1, 64'h1234_5678_0000_0001, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start;
    run_op("R8 start ignored", 32'h0BAD_F00D, 32'h8123_4567, 1'b0, 1'b0, 64'd0, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    logic [63:0] held;
    run_op("R9 prep", 32'h0000_0ABC, 32'h0000_0DEF, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0);
    held = result;
    @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; acc_en = 1'b1; acc_in = '1;
    repeat (3) @(negedge clk);
    check("R9 result held", result, held);
    check("R9 no spurious done R7", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned();
    t_signed();
    t_accum();
    t_short();
    t_busy_start();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule